// File: doc/BRIEF.md
# Latency-Miss Stall Controller

This block sits beside the static schedule of a pipelined accelerator datapath. Every variable-latency operation in that datapath, such as a cache-backed load, a store, or a call that hands control to software and waits for it to come back, is given a fixed expected latency at design time. The static schedule is built on the assumption that each operation completes within that latency. The controller tracks one channel per operation. When an operation has missed its slot, it drives a single global stall that freezes the whole datapath.

Each channel loads a countdown when the datapath issues its operation. The countdown steps once per running cycle. If the countdown reaches its last cycle and no completion strobe is present, the channel is late, and the global stall rises in that same cycle. The stall stays high while any channel is late and falls in the very cycle the last late completion arrives. Completions that arrive early, including those that arrive while the datapath is frozen, retire their channel at once. Countdowns do not move while the stall is high, so frozen time is never charged against any operation.

All pins are plain control strobes. No data passes through the block, so it has no valid/ready handshake and applies no back-pressure beyond the stall itself.

Top module: `vls_stall_ctrl`

## Requirements
- R1: After reset, `stall_o` is low, `run_o` is high, and no channel has an operation outstanding.
- R2: Channel g has an expected latency L taken from bits [4g+3:4g] of the `LAT_VEC` parameter, with L of at least 1. The default is channel 0 = 2, channel 1 = 3 and channel 2 = 5. An issue is sampled on a rising edge; the following cycle is cycle 1. A `done_i` strobe in any cycle 1..L causes no stall.
- R3: If done arrives in cycle d > L, with no other stall involved, `stall_o` is high in cycles L..d-1 and low in cycle d, which is exactly d-L stall cycles. `run_o` is always the inverse of `stall_o`.
- R4: When several channels are late at the same time, `stall_o` stays high until every late channel has received its done strobe. One completion alone does not release it.
- R5: An outstanding channel's countdown does not advance in cycles where `stall_o` is high. Its due cycle moves later by the number of stalled cycles.
- R6: A done strobe that arrives while `stall_o` is high retires that channel's operation. The channel never becomes late afterwards.
- R7: An issue strobe is ignored in a cycle where `stall_o` is high. It is also ignored on a channel that is outstanding and receives no done strobe in that cycle.
- R8: A done strobe on a channel with nothing outstanding is ignored and is not held for a later operation.
- R9: Done and issue on the same outstanding channel in one running cycle retire the old operation and start a new countdown of L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_i | input | NCH | Per-channel issue strobe from the static schedule |
| done_i | input | NCH | Per-channel completion strobe |
| stall_o | output | 1 | Global datapath freeze |
| run_o | output | 1 | Global datapath enable, inverse of stall_o |

## Verification
For every channel, the bench sweeps the completion delay across and beyond that channel's latency and counts the stall cycles. An off-by-one in the countdown load or in the due test would show up as one stall cycle too many or too few. Two channels that both miss, with their completions staggered, catch a controller that releases on the first completion. A short channel that stalls while a longer one is counting catches counters that keep running during the freeze: the long channel would then fall due early and add stall cycles. Further cases cover a completion that lands inside a stall, issues presented during a stall, stray completions on idle channels, and done-plus-issue in one cycle. Each of these exposes a controller that drops, replays or invents an operation, because the stall pattern differs from the one computed.

// File: rtl/vls_pkg.sv
package vls_pkg;
  typedef enum logic {
    CH_IDLE = 1'b0,
    CH_WAIT = 1'b1
  } vls_ch_state_e;
endpackage

// File: rtl/vls_channel.sv
module vls_channel
  import vls_pkg::*;
#(
  parameter int unsigned CW  = 4,
  parameter int unsigned LAT = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic issue_i,
  input  logic done_i,
  input  logic stall_i,
  output logic busy_o,
  output logic late_o
);
  localparam logic [CW-1:0] LOAD_VAL = CW'(LAT);
  localparam logic [CW-1:0] DUE_VAL  = CW'(1);

  vls_ch_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          due, accept;

  assign busy_o = (state_q == CH_WAIT);
  assign due    = busy_o && (cnt_q == DUE_VAL);
  // late: due slot reached and no completion in this cycle
  assign late_o = due && !done_i;
  assign accept = issue_i && !stall_i && (!busy_o || done_i);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (accept) begin
      state_d = CH_WAIT;
      cnt_d   = LOAD_VAL;
    end else if (busy_o && done_i) begin
      state_d = CH_IDLE;
      cnt_d   = '0;
    end else if (busy_o && !stall_i && !due) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= CH_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt_q >= DUE_VAL && cnt_q <= LOAD_VAL)); // R2
  AST_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && stall_i && !done_i) |=> (busy_o && $stable(cnt_q))); // R5
  AST_IDLE_IN_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && stall_i) |=> !busy_o); // R7
  AST_DONE_RETIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && done_i && !issue_i) |=> !busy_o); // R6
endmodule

// File: rtl/vls_late_merge.sv
module vls_late_merge #(
  parameter int unsigned NCH = 3
) (
  input  logic [NCH-1:0] late_i,
  output logic           any_o
);
  assign any_o = |late_i;
endmodule

// File: rtl/vls_stall_ctrl.sv
module vls_stall_ctrl #(
  parameter int unsigned NCH     = 3,
  parameter int unsigned CW      = 4,
  parameter logic [NCH*CW-1:0] LAT_VEC = 12'h532
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] issue_i,
  input  logic [NCH-1:0] done_i,
  output logic           stall_o,
  output logic           run_o
);
  logic [NCH-1:0] busy, late;
  logic           stall;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int unsigned CH_LAT = int'(LAT_VEC[g*CW +: CW]);
    vls_channel #(.CW(CW), .LAT(CH_LAT)) ch_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .issue_i(issue_i[g]),
      .done_i (done_i[g]),
      .stall_i(stall),
      .busy_o (busy[g]),
      .late_o (late[g])
    );
  end

  vls_late_merge #(.NCH(NCH)) merge_i (
    .late_i(late),
    .any_o (stall)
  );

  assign stall_o = stall;
  assign run_o   = !stall;

  AST_STALL_HAS_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (busy != '0)); // R4
  AST_RUN_INVERSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_o != stall_o); // R3
endmodule

// File: tb/vls_stall_ctrl_tb_top.sv
module vls_stall_ctrl_tb_top;
  localparam int NCH = 3;
  localparam int LATS [NCH] = '{2, 3, 5};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] issue = '0, done = '0;
  logic stall, run;
  int n_chk = 0, n_fail = 0, cyc_cnt = 0;

  always #4 clk = ~clk; // 125 MHz

  vls_stall_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue), .done_i(done),
    .stall_o(stall), .run_o(run)
  );

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run did not finish (act=%0d exp<=100000)", cyc_cnt);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample after settle
  task automatic cyc(input logic [NCH-1:0] iss, input logic [NCH-1:0] dn,
                     output logic st);
    @(negedge clk);
    issue = iss; done = dn;
    #1;
    st = stall;
    if (run == stall) check("R3 run inverse", int'(run), int'(!stall));
  endtask

  task automatic idle(input int n);
    logic st;
    for (int i = 0; i < n; i++) cyc('0, '0, st);
  endtask

  initial begin
    logic st;
    int cnt;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 stall after reset", int'(stall), 0);
    check("R1 run after reset", int'(run), 1);
    idle(2);
    check("R1 no outstanding", int'(stall), 0);

    // R2/R3 sweep: per channel, done delay 1..8
    for (int ch = 0; ch < NCH; ch++) begin
      for (int d = 1; d <= 8; d++) begin
        int exp_n;
        logic last_st;
        cnt = 0;
        cyc(NCH'(1) << ch, '0, st);
        for (int k = 1; k <= d; k++) begin
          cyc('0, (k == d) ? (NCH'(1) << ch) : '0, st);
          if (k < d && st) cnt++;
          last_st = st;
        end
        exp_n = (d > LATS[ch]) ? d - LATS[ch] : 0;
        if (d <= LATS[ch]) check("R2 on-time no stall", cnt, 0);
        else check("R3 stall cycles", cnt, exp_n);
        check("R3 release in done cycle", int'(last_st), 0);
        idle(2);
      end
    end

    // R5: ch0 stalls while ch2 counts; ch2 must be frozen
    cnt = 0;
    cyc(3'b101, '0, st);
    for (int k = 1; k <= 10; k++) begin
      cyc('0, (k == 4) ? 3'b001 : (k == 7) ? 3'b100 : 3'b000, st);
      if (st) cnt++;
    end
    check("R5 frozen counter stall count", cnt, 2);
    idle(2);

    // R4: both late, release only after last
    cyc(3'b010, '0, st);
    cnt = 0;
    for (int k = 1; k <= 9; k++) begin
      cyc((k == 1) ? 3'b001 : 3'b000,
          (k == 5) ? 3'b001 : (k == 7) ? 3'b010 : 3'b000, st);
      if (st) cnt++;
      if (k == 5) check("R4 held after first done", int'(st), 1);
      if (k == 7) check("R4 released after last done", int'(st), 0);
    end
    check("R4 stall count", cnt, 4);
    idle(2);

    // R6: ch2 completes during ch0 stall
    cyc(3'b101, '0, st);
    cnt = 0;
    for (int k = 1; k <= 12; k++) begin
      cyc('0, (k == 3) ? 3'b100 : (k == 6) ? 3'b001 : 3'b000, st);
      if (st) cnt++;
    end
    check("R6 done in stall retired", cnt, 4);
    idle(2);

    // R7: issue during stall ignored
    cyc(3'b001, '0, st);
    cnt = 0;
    for (int k = 1; k <= 10; k++) begin
      cyc((k == 3) ? 3'b010 : 3'b000, (k == 4) ? 3'b001 : 3'b000, st);
      if (k == 3) check("R7 stall during issue", int'(st), 1);
      if (k > 4 && st) cnt++;
    end
    check("R7 ignored issue no later stall", cnt, 0);
    idle(2);
    // R7: second issue on busy channel without done ignored
    cyc(3'b100, '0, st);
    cnt = 0;
    for (int k = 1; k <= 8; k++) begin
      cyc((k == 2) ? 3'b100 : 3'b000, (k == 5) ? 3'b100 : 3'b000, st);
      if (st) cnt++;
    end
    check("R7 busy reissue ignored", cnt, 0);
    idle(2);

    // R9: done + issue same cycle restarts countdown
    cyc(3'b001, '0, st);
    cyc('0, '0, st);
    check("R9 no stall before", int'(st), 0);
    cyc(3'b001, 3'b001, st);
    check("R9 on-time done", int'(st), 0);
    cyc('0, '0, st);
    check("R9 new op not yet due", int'(st), 0);
    cyc('0, '0, st);
    check("R9 new op late at L", int'(st), 1);
    cyc('0, 3'b001, st);
    check("R9 release", int'(st), 0);
    idle(2);

    // R8: stray done on idle channel not held
    cyc('0, 3'b010, st);
    cyc(3'b010, '0, st);
    cnt = 0;
    for (int k = 1; k <= 4; k++) begin
      cyc('0, (k == 4) ? 3'b010 : 3'b000, st);
      if (st) cnt++;
    end
    check("R8 stray done ignored", cnt, 1);
    idle(2);
    check("R1 idle at end", int'(stall), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule